// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Processor

This block is a small processor built around one accumulator. It fetches and executes words from an internal memory. Each word holds either an instruction or a signed two's-complement data value. The instruction set has eight operations:

- moving a word between memory and the accumulator, in either direction;
- adding a word to the accumulator and subtracting a word from it;
- a transfer that is always taken;
- two conditional transfers, one taken on a zero accumulator and one on a negative accumulator;
- a stop.

These operations are enough to run loops such as a greatest-common-divisor routine that works by repeated subtraction.

The processor sits idle in a halted state after reset. While it is halted, a loader port writes words into memory. A one-cycle start pulse then sets the instruction counter to a fixed entry address and begins execution. Every instruction takes one fetch cycle and one execute cycle. A stop instruction returns the processor to the halted state, where the results can be read through a debug read port. The debug port is combinational and can be used at any time.

Top module: `acc_cpu`

## Requirements
- R1: After a synchronous reset the processor is halted (`halted` = 1) and executes nothing until `start` is seen.
- R2: While the processor is halted, a `start` pulse makes execution begin at address ENTRY_ADDR. Every instruction takes exactly two clock cycles. A run of N instructions that ends with a stop therefore raises `halted` at the 2N-th rising edge after the edge that sampled `start`.
- R3: Opcode 1 loads the addressed word into the accumulator. Opcode 3 adds the addressed word to the accumulator and opcode 4 subtracts it. Both arithmetic operations wrap modulo 2^DATA_W, so 0x7FFFFF + 1 gives 0x800000.
- R4: Opcode 2 writes the accumulator to the addressed word.
- R5: Opcode 5 always sets the instruction counter to the operand address.
- R6: Opcode 6 jumps to the operand address when the accumulator is zero. Otherwise execution continues at the next address.
- R7: Opcode 8 jumps to the operand address when the accumulator's sign bit (bit DATA_W-1) is set. Otherwise execution continues at the next address.
- R8: Opcodes 7 and 9 to 15 are no-operations. They leave the accumulator and memory unchanged, and execution continues at the next address.
- R9: An instruction word has the opcode in bits [23:20] and the operand address in bits [13:0]. Bits [19:14] are ignored. The memory location used is the address modulo DEPTH, so address 356 selects word 100.
- R10: The loader port (`ld_we`, `ld_addr`, `ld_data`) writes memory only while the processor is halted. A write attempted while it runs has no effect.
- R11: `dbg_data` always shows the memory word selected by `dbg_addr`, with no clock delay.
- R12: The repeated-subtraction GCD program, started with m = 20 and n = 8, halts with 4 in the location of n. It also gives the correct GCD for other positive pairs.
- R13: While the processor is halted and `start` is low, it stays halted and memory changes only through the loader.
- R14: Opcode 0 stops execution and sets `halted`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins execution at ENTRY_ADDR when halted |
| ld_we | input | 1 | Loader write enable (effective only while halted) |
| ld_addr | input | ADDR_W | Loader write address |
| ld_data | input | DATA_W | Loader write data |
| dbg_addr | input | ADDR_W | Debug read address |
| dbg_data | output | DATA_W | Memory word at dbg_addr |
| halted | output | 1 | High while the processor is not executing |

## Verification
The bench builds the block with its default parameters:

- DATA_W = 24, which lets the bench reach the sign bit and the wrap at 0x7FFFFF + 1;
- ADDR_W = 14 with DEPTH = 256, which leaves upper address bits to exercise the modulo aliasing;
- ENTRY_ADDR = 16, a nonzero value, so a start that jumped to address 0 would be caught.

Random positive operand pairs up to 300 drive the GCD loop through many taken and untaken conditional transfers. Directed programs cover each opcode, the undefined codes and the ignored bits in the instruction word.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    typedef enum logic [1:0] {
        PH_HALT  = 2'd0,
        PH_FETCH = 2'd1,
        PH_EXEC  = 2'd2
    } phase_e;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OP_HALT  = 4'd0;
    localparam logic [OPC_W-1:0] OP_LOAD  = 4'd1;
    localparam logic [OPC_W-1:0] OP_STORE = 4'd2;
    localparam logic [OPC_W-1:0] OP_ADD   = 4'd3;
    localparam logic [OPC_W-1:0] OP_SUB   = 4'd4;
    localparam logic [OPC_W-1:0] OP_JMP   = 4'd5;
    localparam logic [OPC_W-1:0] OP_JZ    = 4'd6;
    localparam logic [OPC_W-1:0] OP_JNEG  = 4'd8;

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 14,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [DATA_W-1:0] dbg_data
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [DATA_W-1:0] words_q [DEPTH];

    // Upper address bits alias onto the stored words.
    logic unused_hi;
    assign unused_hi = ^{waddr[ADDR_W-1:IDX_W], raddr[ADDR_W-1:IDX_W],
                         dbg_addr[ADDR_W-1:IDX_W]};

    always_ff @(posedge clk) begin
        if (we) begin
            words_q[waddr[IDX_W-1:0]] <= wdata;
        end
    end

    assign rdata    = words_q[raddr[IDX_W-1:0]];
    assign dbg_data = words_q[dbg_addr[IDX_W-1:0]];
endmodule

// File: rtl/acc_decode.sv
module acc_decode
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 14
) (
    input  logic [DATA_W-1:0] word,
    output logic [ADDR_W-1:0] addr,
    output logic              is_halt,
    output logic              is_load,
    output logic              is_store,
    output logic              is_add,
    output logic              is_sub,
    output logic              is_jmp,
    output logic              is_jz,
    output logic              is_jneg,
    output logic              is_undef
);
    localparam int PAD_W = DATA_W - OPC_W - ADDR_W;

    logic [OPC_W-1:0] opc;
    logic             unused_pad;

    assign opc        = word[DATA_W-1 -: OPC_W];
    assign addr       = word[ADDR_W-1:0];
    assign unused_pad = ^word[ADDR_W +: PAD_W];

    always_comb begin
        is_halt  = (opc == OP_HALT);
        is_load  = (opc == OP_LOAD);
        is_store = (opc == OP_STORE);
        is_add   = (opc == OP_ADD);
        is_sub   = (opc == OP_SUB);
        is_jmp   = (opc == OP_JMP);
        is_jz    = (opc == OP_JZ);
        is_jneg  = (opc == OP_JNEG);
        is_undef = !(is_halt || is_load || is_store || is_add || is_sub ||
                     is_jmp || is_jz || is_jneg);
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int DATA_W = 24
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    input  logic              do_load,
    input  logic              do_add,
    input  logic              do_sub,
    output logic [DATA_W-1:0] acc_next,
    output logic              acc_zero,
    output logic              acc_neg
);
    always_comb begin
        acc_next = acc;
        if (do_load) begin
            acc_next = operand;
        end else if (do_add) begin
            acc_next = acc + operand;
        end else if (do_sub) begin
            acc_next = acc - operand;
        end
    end

    assign acc_zero = (acc == '0);
    assign acc_neg  = acc[DATA_W-1];
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int          DATA_W     = 24,
    parameter int          ADDR_W     = 14,
    parameter int          DEPTH      = 256,
    parameter int unsigned ENTRY_ADDR = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [DATA_W-1:0] dbg_data,
    output logic              halted
);
    localparam logic [ADDR_W-1:0] ENTRY = ADDR_W'(ENTRY_ADDR);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] ic;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] ir;
    } cpu_t;

    cpu_t s_q, s_d;

    logic              mem_we;
    logic [ADDR_W-1:0] mem_wa;
    logic [DATA_W-1:0] mem_wd;
    logic [ADDR_W-1:0] mem_ra;
    logic [DATA_W-1:0] mem_rd;

    logic [ADDR_W-1:0] dec_addr;
    logic dec_halt, dec_load, dec_store, dec_add, dec_sub;
    logic dec_jmp, dec_jz, dec_jneg, dec_undef;

    logic [DATA_W-1:0] alu_acc;
    logic              acc_zero, acc_neg;
    logic              take_jump;

    acc_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
        .word(s_q.ir), .addr(dec_addr),
        .is_halt(dec_halt), .is_load(dec_load), .is_store(dec_store),
        .is_add(dec_add), .is_sub(dec_sub), .is_jmp(dec_jmp),
        .is_jz(dec_jz), .is_jneg(dec_jneg), .is_undef(dec_undef)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .acc(s_q.acc), .operand(mem_rd),
        .do_load(dec_load), .do_add(dec_add), .do_sub(dec_sub),
        .acc_next(alu_acc), .acc_zero(acc_zero), .acc_neg(acc_neg)
    );

    acc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
        .raddr(mem_ra), .rdata(mem_rd),
        .dbg_addr(dbg_addr), .dbg_data(dbg_data)
    );

    assign mem_ra    = (s_q.phase == PH_FETCH) ? s_q.ic : dec_addr;
    assign take_jump = dec_jmp || (dec_jz && acc_zero) || (dec_jneg && acc_neg);
    assign halted    = (s_q.phase == PH_HALT);

    always_comb begin
        s_d    = s_q;
        mem_we = 1'b0;
        mem_wa = ld_addr;
        mem_wd = ld_data;
        unique case (s_q.phase)
            PH_HALT: begin
                if (start) begin
                    s_d.phase = PH_FETCH;
                    s_d.ic    = ENTRY;
                end else if (ld_we) begin
                    mem_we = 1'b1;
                end
            end
            PH_FETCH: begin
                s_d.ir    = mem_rd;
                s_d.phase = PH_EXEC;
            end
            PH_EXEC: begin
                s_d.acc = alu_acc;
                if (dec_halt) begin
                    s_d.phase = PH_HALT;
                end else begin
                    s_d.phase = PH_FETCH;
                    s_d.ic    = take_jump ? dec_addr : s_q.ic + ADDR_W'(1);
                end
                if (dec_store) begin
                    mem_we = 1'b1;
                    mem_wa = dec_addr;
                    mem_wd = s_q.acc;
                end
            end
            default: s_d.phase = PH_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.phase <= PH_HALT;
            s_q.ic    <= '0;
            s_q.acc   <= '0;
            s_q.ir    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R13
    halt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (halted && !start) |=> (halted && s_q.acc == $past(s_q.acc)));

    // R2
    start_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (halted && start) |=> (s_q.phase == PH_FETCH && s_q.ic == ENTRY));

    // R2
    fetch_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_FETCH) |=> (s_q.phase == PH_EXEC));

    // R10
    run_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !halted) |-> (s_q.phase == PH_EXEC && dec_store && mem_wa == dec_addr));

    // R6
    jz_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_EXEC && dec_jz && s_q.acc == '0) |=> (s_q.ic == $past(dec_addr)));

    // R8
    undef_nop_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_EXEC && dec_undef)
        |=> (s_q.acc == $past(s_q.acc) && s_q.ic == $past(s_q.ic) + ADDR_W'(1)
             && s_q.phase == PH_FETCH));

    // R14
    stop_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_EXEC && dec_halt) |=> halted);
endmodule

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
    localparam int DATA_W = 24;
    localparam int ADDR_W = 14;
    localparam int E      = 16;
    localparam int LIMIT  = 50000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              ld_we = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [DATA_W-1:0] ld_data = '0;
    logic [ADDR_W-1:0] dbg_addr = '0;
    logic [DATA_W-1:0] dbg_data;
    logic              halted;

    int errors = 0;
    int checks = 0;
    int cyc;

    acc_cpu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(256), .ENTRY_ADDR(E)) dut (
        .clk(clk), .rst(rst), .start(start), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .dbg_addr(dbg_addr), .dbg_data(dbg_data), .halted(halted)
    );

    always #10 clk = ~clk;

    function automatic logic [DATA_W-1:0] ins(int op, int a, int pad = 0);
        return {op[3:0], pad[5:0], a[13:0]};
    endfunction

    function automatic int gcd(int a, int b);
        int t;
        while (b != 0) begin
            t = a % b; a = b; b = t;
        end
        return a;
    endfunction

    task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [DATA_W-1:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = ADDR_W'(a); ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic rd(int a, output logic [DATA_W-1:0] d);
        dbg_addr = ADDR_W'(a);
        #1 d = dbg_data;
    endtask

    task automatic run(bit inject);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        cyc = 1;
        @(negedge clk);
        start = 1'b0;
        while (!halted && cyc < LIMIT) begin
            ld_we = (inject && cyc == 4);
            ld_addr = ADDR_W'(140); ld_data = 24'h00ABCD;
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        ld_we = 1'b0;
        if (cyc >= LIMIT) check("watchdog", 0, 1);
    endtask

    task automatic load_gcd(int m, int n);
        wr(E + 0, ins(1, 100));  wr(E + 1, ins(4, 101));
        wr(E + 2, ins(8, E + 4)); wr(E + 3, ins(5, E + 1));
        wr(E + 4, ins(3, 101));  wr(E + 5, ins(6, E + 12));
        wr(E + 6, ins(2, 102));  wr(E + 7, ins(1, 101));
        wr(E + 8, ins(2, 100));  wr(E + 9, ins(1, 102));
        wr(E + 10, ins(2, 101)); wr(E + 11, ins(5, E + 0));
        wr(E + 12, ins(0, 0));
        wr(100, m); wr(101, n); wr(102, 0);
    endtask

    initial begin
        #(20 * 190000);
        check("watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 halted after reset", halted, 1);

        // R13: idle while halted, loader writes land (R10), debug reads (R11)
        wr(150, 24'h123456);
        repeat (10) @(negedge clk);
        rd(150, v); check("R13 idle memory", v, 24'h123456);
        check("R13 still halted", halted, 1);

        // R3 R4 R2 arithmetic
        wr(100, 5); wr(101, 7); wr(102, 20); wr(104, 24'h7FFFFF); wr(105, 1);
        wr(E + 0, ins(1, 100)); wr(E + 1, ins(3, 101)); wr(E + 2, ins(4, 102));
        wr(E + 3, ins(2, 103)); wr(E + 4, ins(1, 104)); wr(E + 5, ins(3, 105));
        wr(E + 6, ins(2, 106)); wr(E + 7, ins(0, 0));
        run(0);
        check("R2 cycles for 8 instructions", cyc, 17);
        check("R14 halted after stop", halted, 1);
        rd(103, v); check("R3 R4 5+7-20", v, 24'hFFFFF8);
        rd(106, v); check("R3 wrap 7FFFFF+1", v, 24'h800000);

        // R8 undefined opcodes
        wr(E + 0, ins(1, 100)); wr(E + 1, ins(7, 100)); wr(E + 2, ins(9, 101));
        wr(E + 3, ins(15, 100)); wr(E + 4, ins(2, 107)); wr(E + 5, ins(0, 0));
        run(0);
        rd(107, v); check("R8 acc kept", v, 5);
        rd(100, v); check("R8 memory kept", v, 5);
        check("R8 cycles", cyc, 13);

        // R5 R6 R7 transfers
        wr(110, 0); wr(111, 3); wr(112, 5);
        wr(120, 99); wr(121, 0); wr(122, 99); wr(123, 0); wr(124, 99);
        wr(E + 0, ins(1, 110));  wr(E + 1, ins(6, E + 4)); wr(E + 2, ins(2, 120));
        wr(E + 3, ins(0, 0));    wr(E + 4, ins(1, 111));   wr(E + 5, ins(6, E + 7));
        wr(E + 6, ins(2, 121));  wr(E + 7, ins(4, 112));   wr(E + 8, ins(8, E + 11));
        wr(E + 9, ins(2, 122));  wr(E + 10, ins(0, 0));    wr(E + 11, ins(1, 111));
        wr(E + 12, ins(8, E + 15)); wr(E + 13, ins(2, 123)); wr(E + 14, ins(5, E + 16));
        wr(E + 15, ins(2, 124)); wr(E + 16, ins(0, 0));
        run(0);
        rd(120, v); check("R6 jz taken skips store", v, 99);
        rd(121, v); check("R6 jz not taken", v, 3);
        rd(122, v); check("R7 jneg taken skips store", v, 99);
        rd(123, v); check("R7 jneg not taken", v, 3);
        rd(124, v); check("R5 jmp skips store", v, 99);
        check("R2 cycles transfer program", cyc, 25);

        // R9 ignored bits and address aliasing
        wr(100, 24'h0BEEF1); wr(130, 0);
        wr(E + 0, ins(1, 356, 63)); wr(E + 1, ins(2, 386, 21)); wr(E + 2, ins(0, 0));
        run(0);
        rd(130, v); check("R9 alias store", v, 24'h0BEEF1);
        rd(642, v); check("R9 alias debug read", v, 24'h0BEEF1);

        // R12 directed GCD with R10 write attempt during the run
        wr(140, 77);
        load_gcd(20, 8);
        run(1);
        rd(101, v); check("R12 gcd(20,8)", v, 4);
        rd(140, v); check("R10 loader ignored while running", v, 77);

        // R12 random pairs
        for (int k = 0; k < 10; k++) begin
            int m, n;
            m = 1 + int'($urandom_range(299));
            n = 1 + int'($urandom_range(299));
            load_gcd(m, n);
            run(0);
            rd(101, v);
            check($sformatf("R12 gcd(%0d,%0d)", m, n), v, DATA_W'(gcd(m, n)));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule